// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This unit holds the primary accumulator of a controller CPU together with three condition flags (CC0, CC1, OV) and applies shift and rotate operations to it. Word operations touch only the low 16 bits; double-word operations use all 32 bits. Shifts can be logical, which fills with zeros, or sign-filling to the right. Rotates move all 32 bits, either directly by a count or by one place through the CC1 flag as a 33-bit loop.

The shift count comes from an immediate field when the instruction carries one. Otherwise it comes from the low byte of the secondary accumulator. Each operation completes in the clock cycle in which it is strobed. The surrounding CPU loads the accumulator and the flags through two write ports. The accumulator and flags are visible at the outputs at all times.

Top module: `acc_shift_unit`

## Requirements
- R1: The count is `imm_cnt_i` when `imm_valid_i` is 1 and `accu2_i[7:0]` otherwise; the upper bits of `accu2_i` never affect the result.
- R2: Op 0 shifts `accu1_o[15:0]` left and op 1 shifts it right, both with zero fill. `accu1_o[31:16]` is unchanged, a count of 16 or more gives a low word of zero, and 3 shifted left by 3 gives 24 while 16 shifted right by 2 gives 4.
- R3: Op 2 shifts `accu1_o[15:0]` right and fills with bit 15. A count of 16 or more fills the low word with bit 15, and `accu1_o[31:16]` is unchanged.
- R4: Op 3 is a 32-bit logical left shift, op 4 a 32-bit logical right shift and op 5 a 32-bit right shift that fills with bit 31. A count of 32 or more gives zero for ops 3 and 4 and all copies of bit 31 for op 5.
- R5: After an executed shift (ops 0 to 5), CC1 holds the last bit shifted out and CC0 and OV are 0. The last bit is 0 once the count passes the width for logical shifts, and it is the sign for op 2 and op 5.
- R6: Op 6 rotates all 32 bits left and op 7 rotates them right, by the count modulo 32. CC1 takes the last bit moved, which is result bit 0 for op 6 and result bit 31 for op 7, and CC0 and OV become 0.
- R7: Op 8 (left) and op 9 (right) rotate by exactly one place through CC1 as a 33-bit loop and ignore the count. Left: CC1 takes bit 31 and bit 0 takes the old CC1. Right: CC1 takes bit 0 and bit 31 takes the old CC1. CC0 and OV become 0.
- R8: For ops 0 to 7, a count of zero leaves the accumulator and all three flags unchanged.
- R9: Op codes 10 to 15 change neither the accumulator nor the flags.
- R10: `acc_wr_i` loads `acc_data_i` into the accumulator. `stat_wr_i` loads the flags as OV=`stat_data_i[2]`, CC1=`stat_data_i[1]`, CC0=`stat_data_i[0]`. In a cycle with either write, a strobed operation is ignored.
- R11: Reset clears the accumulator and all flags to 0. An operation strobed with `valid_i` shows its result on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code (0 to 9 defined) |
| imm_valid_i | input | 1 | Immediate count present |
| imm_cnt_i | input | 8 | Immediate count |
| accu2_i | input | 32 | Secondary accumulator (low byte is the count source) |
| acc_wr_i | input | 1 | Accumulator load strobe |
| acc_data_i | input | 32 | Accumulator load value |
| stat_wr_i | input | 1 | Flag load strobe |
| stat_data_i | input | 3 | Flag load value {OV, CC1, CC0} |
| accu1_o | output | 32 | Primary accumulator |
| cc0_o | output | 1 | CC0 flag |
| cc1_o | output | 1 | CC1 flag |
| ov_o | output | 1 | OV flag |

## Verification
The hardest cases to reach are the ones that depend on flag state the unit itself produced. One is the through-CC1 rotates feeding a CC1 value left behind by an earlier shift. The other is a zero-count operation that must preserve flags which are set, although every executed operation clears CC0 and OV. The stimulus reaches these cases by forcing all flags to 1 through the flag write port just before the zero-count and reserved-op cycles. It also chains through-CC1 rotates directly after shifts whose last bit is known. A long random run then mixes counts around 0, 16, 32 and 255 with both count sources.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  typedef enum logic [3:0] {
    OP_SLW = 4'd0,
    OP_SRW = 4'd1,
    OP_SSW = 4'd2,
    OP_SLD = 4'd3,
    OP_SRD = 4'd4,
    OP_SSD = 4'd5,
    OP_ROL = 4'd6,
    OP_ROR = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9
  } shift_op_e;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RIGHT = 2'd1,
    SK_SIGN  = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic ov;
    logic cc1;
    logic cc0;
  } stat_t;

endpackage

// File: rtl/acc_count_sel.sv
module acc_count_sel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             imm_valid_i,
  input  logic [CNT_W-1:0] imm_cnt_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  assign cnt_o  = imm_valid_i ? imm_cnt_i : reg_cnt_i;
  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_shift_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic [W-1:0]     x_i,
  input  shift_kind_e      kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     res_o,
  output logic             last_o
);
  // One guard bit catches the last bit moved out.
  logic [W:0] left_t, right_t, sign_t;

  always_comb begin
    left_t  = {1'b0, x_i} << cnt_i;
    right_t = {x_i, 1'b0} >> cnt_i;
    sign_t  = $signed({x_i, 1'b0}) >>> cnt_i;
    unique case (kind_i)
      SK_LEFT: begin
        res_o  = left_t[W-1:0];
        last_o = left_t[W];
      end
      SK_RIGHT: begin
        res_o  = right_t[W:1];
        last_o = right_t[0];
      end
      default: begin
        res_o  = sign_t[W:1];
        last_o = sign_t[0];
      end
    endcase
  end
endmodule

// File: rtl/acc_rotator.sv
module acc_rotator #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 8
) (
  input  logic [W-1:0]     x_i,
  input  logic             left_i,
  input  logic             thru_i,
  input  logic             cin_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     res_o,
  output logic             last_o
);
  localparam int unsigned SH_W = $clog2(W);

  logic [SH_W-1:0]  amt;
  logic [2*W-1:0]   dbl_l, dbl_r;

  always_comb begin
    amt   = cnt_i[SH_W-1:0];
    dbl_l = {x_i, x_i} << amt;
    dbl_r = {x_i, x_i} >> amt;
    if (thru_i) begin
      // 33-bit loop, one place
      if (left_i) begin
        res_o  = {x_i[W-2:0], cin_i};
        last_o = x_i[W-1];
      end else begin
        res_o  = {cin_i, x_i[W-1:1]};
        last_o = x_i[0];
      end
    end else if (left_i) begin
      res_o  = dbl_l[2*W-1:W];
      last_o = dbl_l[W];
    end else begin
      res_o  = dbl_r[W-1:0];
      last_o = dbl_r[W-1];
    end
  end

  // R6
  always_comb begin
    if (!thru_i) begin
      rot_popcount_chk: assert ($countones(res_o) == $countones(x_i));
    end
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              imm_valid_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [DATA_W-1:0] accu2_i,
  input  logic              acc_wr_i,
  input  logic [DATA_W-1:0] acc_data_i,
  input  logic              stat_wr_i,
  input  logic [2:0]        stat_data_i,
  output logic [DATA_W-1:0] accu1_o,
  output logic              cc0_o,
  output logic              cc1_o,
  output logic              ov_o
);
  localparam int unsigned HI_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] acc_q, acc_d;
  stat_t             st_q, st_d;

  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero;
  logic              is_word, is_dsh, is_rot, is_thru, any_wr, exec;
  shift_kind_e       kind;
  logic [WORD_W-1:0] w_res;
  logic              w_last;
  logic [DATA_W-1:0] d_res, r_res;
  logic              d_last, r_last;
  logic              rot_left;

  acc_count_sel #(.CNT_W(CNT_W)) u_cnt (
    .imm_valid_i (imm_valid_i),
    .imm_cnt_i   (imm_cnt_i),
    .reg_cnt_i   (accu2_i[CNT_W-1:0]),
    .cnt_o       (cnt),
    .zero_o      (cnt_zero)
  );

  always_comb begin
    is_word  = 1'b0;
    is_dsh   = 1'b0;
    is_rot   = 1'b0;
    is_thru  = 1'b0;
    kind     = SK_LEFT;
    rot_left = 1'b0;
    case (op_i)
      OP_SLW: begin is_word = 1'b1; kind = SK_LEFT;  end
      OP_SRW: begin is_word = 1'b1; kind = SK_RIGHT; end
      OP_SSW: begin is_word = 1'b1; kind = SK_SIGN;  end
      OP_SLD: begin is_dsh  = 1'b1; kind = SK_LEFT;  end
      OP_SRD: begin is_dsh  = 1'b1; kind = SK_RIGHT; end
      OP_SSD: begin is_dsh  = 1'b1; kind = SK_SIGN;  end
      OP_ROL: begin is_rot  = 1'b1; rot_left = 1'b1; end
      OP_ROR: begin is_rot  = 1'b1; end
      OP_RLC: begin is_thru = 1'b1; rot_left = 1'b1; end
      OP_RRC: begin is_thru = 1'b1; end
      default: ;
    endcase
  end

  acc_shifter #(.W(WORD_W), .CNT_W(CNT_W)) u_wsh (
    .x_i    (acc_q[WORD_W-1:0]),
    .kind_i (kind),
    .cnt_i  (cnt),
    .res_o  (w_res),
    .last_o (w_last)
  );

  acc_shifter #(.W(DATA_W), .CNT_W(CNT_W)) u_dsh (
    .x_i    (acc_q),
    .kind_i (kind),
    .cnt_i  (cnt),
    .res_o  (d_res),
    .last_o (d_last)
  );

  acc_rotator #(.W(DATA_W), .CNT_W(CNT_W)) u_rot (
    .x_i    (acc_q),
    .left_i (rot_left),
    .thru_i (is_thru),
    .cin_i  (st_q.cc1),
    .cnt_i  (cnt),
    .res_o  (r_res),
    .last_o (r_last)
  );

  assign any_wr = acc_wr_i | stat_wr_i;
  assign exec   = valid_i && !any_wr &&
                  (is_thru || ((is_word || is_dsh || is_rot) && !cnt_zero));

  always_comb begin
    acc_d = acc_q;
    st_d  = st_q;
    if (any_wr) begin
      if (acc_wr_i)  acc_d = acc_data_i;
      if (stat_wr_i) st_d  = stat_t'(stat_data_i);
    end else if (exec) begin
      st_d.cc0 = 1'b0;
      st_d.ov  = 1'b0;
      if (is_word) begin
        acc_d     = {acc_q[DATA_W-1:WORD_W], w_res};
        st_d.cc1  = w_last;
      end else if (is_dsh) begin
        acc_d     = d_res;
        st_d.cc1  = d_last;
      end else begin
        acc_d     = r_res;
        st_d.cc1  = r_last;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      acc_q <= acc_d;
      st_q  <= st_d;
    end
  end

  assign accu1_o = acc_q;
  assign cc0_o   = st_q.cc0;
  assign cc1_o   = st_q.cc1;
  assign ov_o    = st_q.ov;

  // R2
  word_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_wr && is_word) |=> accu1_o[DATA_W-1:DATA_W-HI_W] == $past(accu1_o[DATA_W-1:DATA_W-HI_W]));

  // R2
  word_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_wr && (op_i == OP_SLW || op_i == OP_SRW) && cnt >= CNT_W'(WORD_W))
    |=> accu1_o[WORD_W-1:0] == '0);

  // R5
  flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec) |=> (!cc0_o && !ov_o));

  // R7
  thru_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_wr && op_i == OP_RLC)
    |=> (accu1_o[0] == $past(cc1_o) && cc1_o == $past(accu1_o[DATA_W-1])));

  // R8
  zero_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_wr && cnt_zero && !is_thru)
    |=> ($stable(accu1_o) && $stable(cc0_o) && $stable(cc1_o) && $stable(ov_o)));

  // R9
  reserved_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_wr && op_i > OP_RRC)
    |=> ($stable(accu1_o) && $stable(cc1_o) && $stable(cc0_o) && $stable(ov_o)));

endmodule

// File: tb/acc_shift_unit_tb_top.sv
`timescale 1ns/1ps
module acc_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, imm_valid, acc_wr, stat_wr;
  logic [3:0]  op;
  logic [7:0]  imm;
  logic [31:0] accu2, acc_data;
  logic [2:0]  stat_data;
  logic [31:0] accu1;
  logic        cc0, cc1, ov;

  logic [31:0] m_acc;
  logic        m_cc0, m_cc1, m_ov;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  acc_shift_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .imm_valid_i(imm_valid), .imm_cnt_i(imm), .accu2_i(accu2),
    .acc_wr_i(acc_wr), .acc_data_i(acc_data), .stat_wr_i(stat_wr),
    .stat_data_i(stat_data), .accu1_o(accu1), .cc0_o(cc0), .cc1_o(cc1), .ov_o(ov)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3, 4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (accu1 !== m_acc || cc0 !== m_cc0 || cc1 !== m_cc1 || ov !== m_ov) begin
      n_fail++;
      $display("FAIL %s: got acc=%h ov=%b cc1=%b cc0=%b exp acc=%h ov=%b cc1=%b cc0=%b",
               tag, accu1, ov, cc1, cc0, m_acc, m_ov, m_cc1, m_cc0);
    end
  endtask

  // Behavioural model: bit-at-a-time loops
  task automatic model(input logic v, input logic [3:0] o, input logic iv,
                       input logic [7:0] ic, input logic [31:0] a2,
                       input logic aw, input logic [31:0] ad,
                       input logic sw, input logic [2:0] sd);
    int n;
    logic [15:0] w;
    logic [31:0] d;
    logic last;
    if (aw || sw) begin
      if (aw) m_acc = ad;
      if (sw) {m_ov, m_cc1, m_cc0} = sd;
    end else if (v) begin
      n = iv ? int'(ic) : int'(a2[7:0]);
      w = m_acc[15:0];
      d = m_acc;
      last = 1'b0;
      if (o <= 4'd7 && n > 0) begin
        for (int i = 0; i < n; i++) begin
          case (o)
            4'd0: begin last = w[15]; w = {w[14:0], 1'b0}; end
            4'd1: begin last = w[0];  w = {1'b0, w[15:1]}; end
            4'd2: begin last = w[0];  w = {w[15], w[15:1]}; end
            4'd3: begin last = d[31]; d = {d[30:0], 1'b0}; end
            4'd4: begin last = d[0];  d = {1'b0, d[31:1]}; end
            4'd5: begin last = d[0];  d = {d[31], d[31:1]}; end
            4'd6: begin last = d[31]; d = {d[30:0], d[31]}; end
            default: begin last = d[0]; d = {d[0], d[31:1]}; end
          endcase
        end
        if (o <= 4'd2) m_acc[15:0] = w; else m_acc = d;
        m_cc1 = last; m_cc0 = 1'b0; m_ov = 1'b0;
      end else if (o == 4'd8) begin
        last = d[31]; m_acc = {d[30:0], m_cc1};
        m_cc1 = last; m_cc0 = 1'b0; m_ov = 1'b0;
      end else if (o == 4'd9) begin
        last = d[0]; m_acc = {m_cc1, d[31:1]};
        m_cc1 = last; m_cc0 = 1'b0; m_ov = 1'b0;
      end
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic iv,
                      input logic [7:0] ic, input logic [31:0] a2,
                      input logic aw, input logic [31:0] ad,
                      input logic sw, input logic [2:0] sd, input string tag);
    valid = v; op = o; imm_valid = iv; imm = ic; accu2 = a2;
    acc_wr = aw; acc_data = ad; stat_wr = sw; stat_data = sd;
    model(v, o, iv, ic, a2, aw, ad, sw, sd);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ld(input logic [31:0] val);
    step(1'b0, 4'd0, 1'b0, 8'd0, 32'h0, 1'b1, val, 1'b0, 3'b0, "R10");
  endtask

  task automatic setst(input logic [2:0] s);
    step(1'b0, 4'd0, 1'b0, 8'd0, 32'h0, 1'b0, 32'h0, 1'b1, s, "R10");
  endtask

  // immediate count; accu2 low byte set to a decoy
  task automatic sop(input logic [3:0] o, input logic [7:0] c, input string tag);
    step(1'b1, o, 1'b1, c, 32'h5A5A_5A77, 1'b0, 32'h0, 1'b0, 3'b0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; valid = 0; op = 0; imm_valid = 0; imm = 0; accu2 = 0;
    acc_wr = 0; acc_data = 0; stat_wr = 0; stat_data = 0;
    m_acc = 32'h0; m_cc0 = 0; m_cc1 = 0; m_ov = 0;
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11");

    // R2 arithmetic examples
    ld(32'hDEAD_0003); sop(4'd0, 8'd3, "R2");   // low word 24
    ld(32'hBEEF_0010); sop(4'd1, 8'd2, "R2");   // low word 4
    ld(32'h1234_C001); sop(4'd0, 8'd1, "R5");
    sop(4'd1, 8'd16, "R2");
    ld(32'hFFFF_FFFF); sop(4'd0, 8'd17, "R2");
    ld(32'h0000_8001); sop(4'd1, 8'd255, "R2");

    // R1 count source
    ld(32'h0000_00F0);
    step(1'b1, 4'd1, 1'b0, 8'd9, 32'hFFFF_FF05, 1'b0, 0, 1'b0, 0, "R1");
    ld(32'h0000_00F0);
    step(1'b1, 4'd1, 1'b1, 8'd2, 32'h0000_0007, 1'b0, 0, 1'b0, 0, "R1");

    // R3 sign word shifts
    ld(32'h1234_8000); sop(4'd2, 8'd3, "R3");
    sop(4'd2, 8'd20, "R3");
    ld(32'hFFFF_7FFF); sop(4'd2, 8'd15, "R3");

    // R4 double word shifts
    ld(32'h8000_0001); sop(4'd3, 8'd1, "R4");
    ld(32'h8000_0001); sop(4'd4, 8'd31, "R4");
    ld(32'h8000_00F0); sop(4'd5, 8'd4, "R4");
    ld(32'h8000_00F0); sop(4'd5, 8'd40, "R4");
    ld(32'h0000_0001); sop(4'd3, 8'd32, "R5");
    ld(32'hFFFF_FFFF); sop(4'd3, 8'd33, "R4");

    // R6 rotates
    ld(32'h8000_000F); sop(4'd6, 8'd4, "R6");
    sop(4'd7, 8'd8, "R6");
    sop(4'd6, 8'd32, "R6");
    sop(4'd7, 8'd33, "R6");

    // R7 through CC1, fed by shift-produced CC1
    ld(32'h0000_8000); sop(4'd0, 8'd1, "R5");   // CC1 = 1
    sop(4'd8, 8'd0, "R7");
    sop(4'd8, 8'd5, "R7");
    setst(3'b010);
    sop(4'd9, 8'd0, "R7");
    sop(4'd9, 8'd200, "R7");

    // R8 zero count with all flags set
    ld(32'hCAFE_F00D); setst(3'b111);
    sop(4'd3, 8'd0, "R8");
    sop(4'd6, 8'd0, "R8");
    step(1'b1, 4'd2, 1'b0, 8'd4, 32'hFFFF_FF00, 1'b0, 0, 1'b0, 0, "R8");

    // R9 reserved codes
    for (int k = 10; k < 16; k++) sop(4'(k), 8'd3, "R9");

    // R10 writes suppress ops
    step(1'b1, 4'd3, 1'b1, 8'd4, 0, 1'b1, 32'h1357_9BDF, 1'b0, 0, "R10");
    step(1'b1, 4'd8, 1'b1, 8'd1, 0, 1'b0, 0, 1'b1, 3'b101, "R10");

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      logic [7:0]  c;
      logic [3:0]  o;
      r = $urandom;
      o = 4'($urandom % 11);
      case ($urandom % 6)
        0: c = 8'd0;
        1: c = 8'd16;
        2: c = 8'd32;
        3: c = 8'd255;
        default: c = 8'($urandom);
      endcase
      if (k % 7 == 0) ld(r);
      else if (k % 13 == 0) setst(3'($urandom));
      else step(1'b1, o, r[0], c, {r[31:8], c ^ {8{r[0]}}}, 1'b0, 0, 1'b0, 0, tag_of(o));
    end

    done = 1;
    finish_run();
  end
endmodule